// File: doc/BRIEF.md
# Dashed Line Rasterizer

This block turns a stream of signed vertices into the sequence of pixels lying on the straight lines between them. Each pixel is chosen by integer error-term stepping, and all eight octants are handled. A command is a run of vertices that ends with a flagged last vertex. The mode flag on the first vertex picks the kind of command. In connected mode each new vertex closes the current line and opens the next one. In segment mode vertices are taken in pairs, and each pair is an independent line.

A pattern of up to eight dash lengths splits the pixels of a command into alternating on and off stretches. A transparency switch chooses what happens to off pixels. With transparency on, they are dropped. With it off, they are sent out tagged for the background colour. A window origin offset is added to every emitted pixel, which puts the output in screen coordinates. Pixels leave on a valid/ready stream, and a stalled output freezes the stepping without losing any state.

Top module: `dash_line_raster`

## Requirements
- R1: After reset `pixValid` is 0 and `vtxReady` is 1.
- R2: In connected mode, line k (k ≥ 2) starts at the end vertex of line k−1. The shared vertex pixel is emitted only once, as the last pixel of line k−1.
- R3: In segment mode, each line takes two new vertices (start, end), emits both endpoints, and is not joined to the previous line.
- R4: Pixels of a line run from start to end. Each step changes X and Y by at most one. The pixel choice follows the error-term rule err=|dx|−|dy|, e2=2·err: X steps when e2 ≥ −|dy|, and Y steps when e2 ≤ |dx|. This holds in every octant.
- R5: A line whose start equals its end emits exactly one pixel (segment mode, or the first line of a connected command).
- R6: Vertex X and Y are 16-bit two's complement, so negative coordinates are drawn correctly.
- R7: `dashLens` holds entry i in bits [8i+7:8i]. Entries are used in order 0,1,2,…. Even entries are on phases and odd entries are off phases, and each covers that many pixels. A zero entry, or passing entry 7, wraps back to entry 0. When entry 0 is zero, every pixel is on.
- R8: With `transparent`=1, off-phase pixels are not emitted. The dash position still advances over them.
- R9: With `transparent`=0, off-phase pixels are emitted with `pixBg`=1, and on-phase pixels with `pixBg`=0.
- R10: `pixX`/`pixY` equal the line coordinate plus `originX`/`originY`, modulo 2^16.
- R11: The dash position carries across all lines of a command. It restarts at entry 0, count 0, when the first vertex of a new command is accepted.
- R12: While `pixValid`=1 and `pixReady`=0, the output pixel and tag stay unchanged. No pixel is lost or repeated.
- R13: `vtxReady` is 0 whenever a line is being drawn (never both `vtxReady` and `pixValid`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vtxValid | input | 1 | Vertex offered |
| vtxReady | output | 1 | Vertex accepted this cycle when valid |
| vtxX | input | 16 | Vertex X, two's complement, window relative |
| vtxY | input | 16 | Vertex Y, two's complement, window relative |
| vtxLast | input | 1 | Vertex is the last of its command |
| vtxSeg | input | 1 | Mode on the first vertex of a command: 1 segment, 0 connected |
| dashLens | input | 64 | Eight 8-bit dash lengths, entry i at bits [8i+7:8i] |
| transparent | input | 1 | 1 drops off-phase pixels, 0 emits them as background |
| originX | input | 16 | Window origin X added to output |
| originY | input | 16 | Window origin Y added to output |
| pixValid | output | 1 | Output pixel valid |
| pixReady | input | 1 | Output pixel taken |
| pixX | output | 16 | Screen X |
| pixY | output | 16 | Screen Y |
| pixBg | output | 1 | 1 background colour, 0 foreground colour |

## Verification
The bench uses the default parameters: 16-bit coordinates and eight 8-bit dash lengths. With these, a full eight-entry pattern can wrap, a short pattern can end on a zero entry, and an origin sum can wrap past the signed X limit. Lines a few dozen pixels long cover every octant, negative vertices, and zero-length lines. Dash patterns are chosen so that a phase boundary falls inside a connected joint. A pseudo-random ready pattern holds the output under back-pressure across dash boundaries and line joints.

// File: rtl/dlr_pkg.sv
package dlr_pkg;

  typedef struct packed {
    logic loadStart;
    logic loadEnd;
    logic step;
  } dlr_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_NEED_END,
    ST_DRAW,
    ST_NEED_START
  } dlr_state_t;

endpackage

// File: rtl/dlr_dp.sv
module dlr_dp
  import dlr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dlr_strobe_t          strobe,
  input  logic signed [CW-1:0] vtxX,
  input  logic signed [CW-1:0] vtxY,
  input  logic        [CW-1:0] originX,
  input  logic        [CW-1:0] originY,
  output logic        [CW-1:0] scrX,
  output logic        [CW-1:0] scrY,
  output logic                 atEnd
);
  localparam int EW = CW + 4;

  logic signed [CW-1:0] curX, curY, endX, endY;
  logic signed [EW-1:0] dxAbs, dyNeg, err;
  logic                 sx, sy;

  logic signed [EW-1:0] diffX, diffY, absX, absY, e2, errNext;
  logic                 moveX, moveY;
  logic signed [CW-1:0] stepX, stepY;

  always_comb begin
    diffX   = EW'(vtxX) - EW'(curX);
    diffY   = EW'(vtxY) - EW'(curY);
    absX    = diffX[EW-1] ? -diffX : diffX;
    absY    = diffY[EW-1] ? -diffY : diffY;
    e2      = err <<< 1;
    moveX   = (e2 >= dyNeg);
    moveY   = (e2 <= dxAbs);
    errNext = err + (moveX ? dyNeg : '0) + (moveY ? dxAbs : '0);
    stepX   = moveX ? (sx ? {CW{1'b1}} : CW'(1)) : '0;
    stepY   = moveY ? (sy ? {CW{1'b1}} : CW'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curX <= '0; curY <= '0; endX <= '0; endY <= '0;
      dxAbs <= '0; dyNeg <= '0; err <= '0; sx <= 1'b0; sy <= 1'b0;
    end else if (strobe.loadStart) begin
      curX <= vtxX;
      curY <= vtxY;
    end else if (strobe.loadEnd) begin
      endX  <= vtxX;
      endY  <= vtxY;
      dxAbs <= absX;
      dyNeg <= -absY;
      err   <= absX - absY;
      sx    <= diffX[EW-1];
      sy    <= diffY[EW-1];
    end else if (strobe.step) begin
      curX <= curX + stepX;
      curY <= curY + stepY;
      err  <= errNext;
    end
  end

  assign atEnd = (curX == endX) && (curY == endY);
  assign scrX  = curX + originX;
  assign scrY  = curY + originY;

  // Checker-side distance to the end point (Chebyshev metric)
  logic signed [EW-1:0] remX, remY, remAx, remAy, remDist;
  always_comb begin
    remX    = EW'(endX) - EW'(curX);
    remY    = EW'(endY) - EW'(curY);
    remAx   = remX[EW-1] ? -remX : remX;
    remAy   = remY[EW-1] ? -remY : remY;
    remDist = (remAx > remAy) ? remAx : remAy;
  end

  // R4: every step moves one pixel closer along the major axis
  assert_approach_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (remDist == $past(remDist) - EW'(1)));

  // R4: no coordinate jumps by more than one per step
  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> ((curX - $past(curX)) inside {CW'(0), CW'(1), {CW{1'b1}}}) &&
                    ((curY - $past(curY)) inside {CW'(0), CW'(1), {CW{1'b1}}}));

  // R2: taking an end vertex never moves the current (joint) point
  assert_joint_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEnd |=> ($stable(curX) && $stable(curY)));

endmodule

// File: rtl/dlr_ctrl.sv
module dlr_ctrl
  import dlr_pkg::*;
#(
  parameter int DASH_N = 8,
  parameter int LEN_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    vtxValid,
  input  logic                    vtxLast,
  input  logic                    vtxSeg,
  input  logic [DASH_N*LEN_W-1:0] dashLens,
  input  logic                    transparent,
  input  logic                    pixReady,
  input  logic                    atEnd,
  output logic                    vtxReady,
  output logic                    pixValid,
  output logic                    pixBg,
  output dlr_strobe_t             strobe
);
  localparam int IW = (DASH_N > 1) ? $clog2(DASH_N) : 1;

  dlr_state_t        state;
  logic              segMode, lastLine, skipJoint;
  logic [IW-1:0]     dashIdx, idxInc;
  logic [LEN_W-1:0]  dashCnt;
  logic [LEN_W-1:0]  lenArr [DASH_N];

  for (genvar g = 0; g < DASH_N; g++) begin : g_len
    assign lenArr[g] = dashLens[g*LEN_W +: LEN_W];
  end

  logic vtxAcc, inDraw, solid, offPhase, suppress, adv, dashAdv, wrapIdx, segEnd;

  always_comb begin
    vtxReady = (state != ST_DRAW);
    vtxAcc   = vtxValid && vtxReady;
    inDraw   = (state == ST_DRAW);
    solid    = (lenArr[0] == '0);
    offPhase = !solid && dashIdx[0];
    suppress = skipJoint || (offPhase && transparent);
    pixValid = inDraw && !suppress;
    pixBg    = offPhase;
    adv      = inDraw && (suppress || pixReady);
    dashAdv  = adv && !skipJoint && !solid;
    idxInc   = dashIdx + IW'(1);
    wrapIdx  = (dashIdx == IW'(DASH_N - 1)) || (lenArr[idxInc] == '0);
    segEnd   = ({1'b0, dashCnt} + (LEN_W+1)'(1)) >= {1'b0, lenArr[dashIdx]};
    strobe.loadStart = vtxAcc && ((state == ST_IDLE) || (state == ST_NEED_START));
    strobe.loadEnd   = vtxAcc && (state == ST_NEED_END);
    strobe.step      = adv && !atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; segMode <= 1'b0; lastLine <= 1'b0; skipJoint <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (vtxAcc) begin
          segMode   <= vtxSeg;
          skipJoint <= 1'b0;
          state     <= vtxLast ? ST_IDLE : ST_NEED_END;
        end
        ST_NEED_START: if (vtxAcc) begin
          skipJoint <= 1'b0;
          state     <= vtxLast ? ST_IDLE : ST_NEED_END;
        end
        ST_NEED_END: if (vtxAcc) begin
          lastLine <= vtxLast;
          state    <= ST_DRAW;
        end
        ST_DRAW: if (adv) begin
          skipJoint <= 1'b0;
          if (atEnd) begin
            if (lastLine)     state <= ST_IDLE;
            else if (segMode) state <= ST_NEED_START;
            else begin
              state     <= ST_NEED_END;
              skipJoint <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dashIdx <= '0; dashCnt <= '0;
    end else if (vtxAcc && state == ST_IDLE) begin
      dashIdx <= '0; dashCnt <= '0;
    end else if (dashAdv) begin
      if (segEnd) begin
        dashCnt <= '0;
        dashIdx <= wrapIdx ? '0 : idxInc;
      end else begin
        dashCnt <= dashCnt + LEN_W'(1);
      end
    end
  end

  // R12: a refused pixel stays offered with the same colour tag
  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixBg)));

endmodule

// File: rtl/dash_line_raster.sv
module dash_line_raster
  import dlr_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int DASH_N  = 8,
  parameter int LEN_W   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    vtxValid,
  output logic                    vtxReady,
  input  logic [COORD_W-1:0]      vtxX,
  input  logic [COORD_W-1:0]      vtxY,
  input  logic                    vtxLast,
  input  logic                    vtxSeg,
  input  logic [DASH_N*LEN_W-1:0] dashLens,
  input  logic                    transparent,
  input  logic [COORD_W-1:0]      originX,
  input  logic [COORD_W-1:0]      originY,
  output logic                    pixValid,
  input  logic                    pixReady,
  output logic [COORD_W-1:0]      pixX,
  output logic [COORD_W-1:0]      pixY,
  output logic                    pixBg
);
  dlr_strobe_t strobe;
  logic        atEnd;

  dlr_ctrl #(.DASH_N(DASH_N), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .vtxValid(vtxValid), .vtxLast(vtxLast), .vtxSeg(vtxSeg),
    .dashLens(dashLens), .transparent(transparent), .pixReady(pixReady), .atEnd(atEnd),
    .vtxReady(vtxReady), .pixValid(pixValid), .pixBg(pixBg), .strobe(strobe)
  );

  dlr_dp #(.CW(COORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .vtxX(vtxX), .vtxY(vtxY), .originX(originX), .originY(originY),
    .scrX(pixX), .scrY(pixY), .atEnd(atEnd)
  );

  // R4: the datapath is only stepped while the end point is still ahead
  assert_step_before_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> !atEnd);

endmodule

// File: tb/dash_line_raster_tb.sv
`timescale 1ns/1ps
module dash_line_raster_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        vtxValid = 1'b0, vtxLast = 1'b0, vtxSeg = 1'b0, transparent = 1'b0, pixReady = 1'b1;
  logic [15:0] vtxX = '0, vtxY = '0, originX = '0, originY = '0;
  logic [63:0] dashLens = '0;
  logic        vtxReady, pixValid, pixBg;
  logic [15:0] pixX, pixY;

  dash_line_raster u_dut (
    .clk(clk), .rstN(rstN), .vtxValid(vtxValid), .vtxReady(vtxReady), .vtxX(vtxX), .vtxY(vtxY),
    .vtxLast(vtxLast), .vtxSeg(vtxSeg), .dashLens(dashLens), .transparent(transparent),
    .originX(originX), .originY(originY), .pixValid(pixValid), .pixReady(pixReady),
    .pixX(pixX), .pixY(pixY), .pixBg(pixBg)
  );

  int nChecks = 0, nFails = 0;
  int vxq[$], vyq[$];
  logic [32:0] expq[$];
  int rIdx, rCnt;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int len(int i);
    return int'(dashLens[i*8 +: 8]);
  endfunction

  // Expected pixels from the requirements (R2..R11)
  task automatic refLine(int x0, int y0, int x1, int y1, bit skipFirst);
    int dx = (x1 > x0) ? x1 - x0 : x0 - x1;
    int dy = (y1 > y0) ? y0 - y1 : y1 - y0;
    int sx = (x0 < x1) ? 1 : -1;
    int sy = (y0 < y1) ? 1 : -1;
    int err = dx + dy;
    int x = x0, y = y0;
    bit first = 1;
    forever begin
      if (!(first && skipFirst)) begin
        bit solid = (len(0) == 0);
        bit off = !solid && rIdx[0];
        if (!(off && transparent))
          expq.push_back({off, 16'(x + int'(originX)), 16'(y + int'(originY))});
        if (!solid) begin
          if (rCnt + 1 >= len(rIdx)) begin
            rCnt = 0;
            if (rIdx == 7 || len(rIdx + 1) == 0) rIdx = 0; else rIdx++;
          end else rCnt++;
        end
      end
      first = 0;
      if (x == x1 && y == y1) break;
      begin
        int e2 = 2 * err;
        if (e2 >= dy) begin err += dy; x += sx; end
        if (e2 <= dx) begin err += dx; y += sy; end
      end
    end
  endtask

  task automatic buildExpected(bit seg);
    expq.delete();
    rIdx = 0; rCnt = 0;
    if (seg) begin
      for (int i = 0; i + 1 < vxq.size(); i += 2) refLine(vxq[i], vyq[i], vxq[i+1], vyq[i+1], 0);
    end else begin
      for (int i = 1; i < vxq.size(); i++) refLine(vxq[i-1], vyq[i-1], vxq[i], vyq[i], i > 1);
    end
  endtask

  task automatic drive(bit seg);
    for (int i = 0; i < vxq.size(); i++) begin
      @(negedge clk);
      vtxValid = 1'b1; vtxX = 16'(vxq[i]); vtxY = 16'(vyq[i]);
      vtxLast = (i == vxq.size() - 1); vtxSeg = seg;
      while (!vtxReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    vtxValid = 1'b0;
  endtask

  task automatic collect(string tag, bit stall);
    int got = 0, idle = 0;
    bit held = 0, both = 0;
    logic [32:0] hv;
    while (got < expq.size() && idle < 2000) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pixReady = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
      if (pixValid && vtxReady) both = 1;
      if (held) check(pixValid && {pixBg, pixX, pixY} == hv, "R12", "held pixel", {pixValid, pixBg, pixX, pixY}, {1'b1, hv});
      held = 0;
      if (pixValid) begin
        idle = 0;
        if (pixReady) begin
          check({pixBg, pixX, pixY} == expq[got], tag, $sformatf("pixel %0d", got), {pixBg, pixX, pixY}, expq[got]);
          got++;
        end else begin
          held = 1; hv = {pixBg, pixX, pixY};
        end
      end else idle++;
    end
    check(got == expq.size(), tag, "pixel count", got, expq.size());
    pixReady = 1'b1;
    begin
      int extra = 0;
      repeat (12) begin
        @(negedge clk);
        if (pixValid) extra++;
        if (pixValid && vtxReady) both = 1;
      end
      check(extra == 0, tag, "extra pixels", extra, 0);
    end
    check(!both, "R13", "vtxReady with pixValid", both, 0);
  endtask

  task automatic runCmd(string tag, bit seg, bit stall);
    buildExpected(seg);
    fork
      drive(seg);
      collect(tag, stall);
    join
  endtask

  task automatic setVerts(int xs[], int ys[]);
    vxq.delete(); vyq.delete();
    foreach (xs[i]) begin vxq.push_back(xs[i]); vyq.push_back(ys[i]); end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(pixValid == 1'b0, "R1", "pixValid after reset", pixValid, 0);
    check(vtxReady == 1'b1, "R1", "vtxReady after reset", vtxReady, 1);
  endtask

  task automatic testOctants();  // R3 R4 R6
    dashLens = '0; transparent = 0; originX = 0; originY = 0;
    setVerts('{0,7, 0,3, 0,-3, -1,-8, 2,-5, 0,-3, 10,13, 0,7, 0,6, 0,0},
             '{0,3, 0,7, 0,7, -1,2, 2,-1, 0,-7, -4,-11, 0,-3, 0,0, 0,-5});
    runCmd("R4", 1, 0);
  endtask

  task automatic testZeroLen();  // R5
    setVerts('{5,5, 9,9}, '{-5,-5, 2,2});
    runCmd("R5", 1, 0);
    setVerts('{3,3}, '{3,3});
    runCmd("R5", 0, 0);
  endtask

  task automatic testPolyOpaque();  // R2 R9 R11
    dashLens = {32'h0, 8'd2, 8'd1, 8'd3, 8'd2};
    transparent = 0;
    setVerts('{0,9,9,-4,-4}, '{0,2,9,5,5});
    runCmd("R2", 0, 0);
  endtask

  task automatic testTransparent();  // R7 R8 R11
    dashLens = {8'd2, 8'd5, 8'd1, 8'd2, 8'd4, 8'd1, 8'd2, 8'd3};
    transparent = 1;
    setVerts('{0,20,20}, '{0,0,-15});
    runCmd("R8", 0, 0);
    runCmd("R11", 0, 0);
    dashLens = {40'h0, 8'd4, 8'd3, 8'd2};
    setVerts('{0,30}, '{0,10});
    runCmd("R7", 1, 0);
  endtask

  task automatic testOrigin();  // R6 R10
    dashLens = '0; transparent = 0;
    originX = 16'h7FF0; originY = 16'd5;
    setVerts('{0,40, -20,-30}, '{0,3, -30,-20});
    runCmd("R10", 1, 0);
    originX = 16'd100; originY = 16'hFFCE;
    setVerts('{-32000,-31990}, '{-7,4});
    runCmd("R6", 1, 0);
    originX = 0; originY = 0;
  endtask

  task automatic testStall();  // R12
    dashLens = {40'h0, 8'd2, 8'd3, 8'd2};
    transparent = 0;
    setVerts('{0,12,2,-6}, '{0,5,14,-3});
    runCmd("R12", 0, 1);
    transparent = 1;
    runCmd("R12", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testOctants();
    testZeroLen();
    testPolyOpaque();
    testTransparent();
    testOrigin();
    testStall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule